// File: doc/BRIEF.md
# DMA Channel Busy Status Register

This block holds one busy flag for each DMA channel and presents the flags to the CPU as one 32-bit status word. A channel's flag goes high when an operand transfer (non-stop transfer) starts on that channel. It drops when the transfer completes normally, or when software writes 1 to the flag's bit. For a channel that works in external mode, the flag also drops as soon as the last data write of the transfer begins. It does not wait for the external bus access to finish.

The channel engines send the block single-cycle event pulses that are synchronous to the register clock: transfer start, last-write start, normal completion and forced abort. A forced abort leaves the flag as it is, so that software can see which channels were interrupted. Software then clears those flags by writing 1 to them. The CPU side has a 32-bit write data bus, a write strobe and a read strobe. Read data is registered and appears in the cycle after the read strobe.

Top module: `dma_busy_status`

## Requirements
- R1: Channel c is reported in status bit 31-c: bit 31 is channel 0 and bit 24 is channel 7. A write to bit 31-c acts only on channel c.
- R2: Status bits 23 to 0 always read as 0. Writing 1 to any of them changes no channel flag.
- R3: While rst_n is low at a clock edge, every flag is cleared and rd_data is 0.
- R4: A start pulse on a channel sets that channel's flag at the same clock edge.
- R5: A completion pulse clears that channel's flag, unless a start pulse for the same channel arrives in the same cycle.
- R6: A write with 1 in a channel bit clears that flag. A write with 0 in that bit leaves the flag unchanged.
- R7: A forced-abort pulse has no effect on any flag.
- R8: A last-write-start pulse clears the channel's flag when that channel's ext_mode input is 1. When ext_mode is 0, the pulse has no effect.
- R9: A start pulse and a software write-1 clear on the same channel in the same cycle leave the flag set.
- R10: A start pulse and a completion pulse on the same channel in the same cycle leave the flag set.
- R11: rd_data is updated at the clock edge where rd_en is high. It then shows the flags as they stood before that edge, without any event from that same cycle. After an edge where rd_en is low, rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_start | input | 8 | Per-channel transfer-start pulse |
| ch_last_wr | input | 8 | Per-channel pulse marking the start of the last data write |
| ch_done | input | 8 | Per-channel normal-completion pulse |
| ch_abort | input | 8 | Per-channel forced-abort pulse |
| ch_ext | input | 8 | Per-channel level, 1 when the channel targets an external device |
| wr_en | input | 1 | CPU write strobe (write-1-to-clear) |
| wr_data | input | 32 | CPU write data |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |

## Verification
An event pulse changes its channel's flag at the edge that samples it. A read strobe issued in the next cycle returns that new flag on rd_data one edge later. A read strobe in the same cycle as the event still returns the old flag. The bench drives inputs 1 ns after each rising edge. It works out the expected word before that edge from its own model of the flags, and compares rd_data 1 ns after the edge. Every cycle is checked in this way, so both the one-cycle read latency and the zero value after a cycle without a read strobe are covered.

// File: rtl/dma_busy_pkg.sv
// Package: shared sizing for the DMA busy-status register.
// Assumes channel bits occupy the top of the word, channel 0 at the MSB.
package dma_busy_pkg;
    localparam int unsigned DEF_NCH   = 8;
    localparam int unsigned DEF_WIDTH = 32;
endpackage

// File: rtl/dma_busy_flag.sv
// Module: one channel's busy flag.
// Sets on transfer start; clears on normal completion, on last-write start in
// external mode, or on software write-1. Set has priority over every clear.
// Forced abort is observed only by the checks here; it never changes the flag.
// Assumes all event inputs are single-cycle pulses in the clk domain.
module dma_busy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start_p,
    input  logic done_p,
    input  logic last_wr_p,
    input  logic abort_p,
    input  logic ext_mode,
    input  logic sw_clr,
    output logic busy
);
    logic clr_any;

    // Gather every clearing cause for this channel.
    always_comb begin
        clr_any = done_p | (ext_mode & last_wr_p) | sw_clr;
    end

    // Flag register: reset, then set-wins-over-clear update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (start_p) begin
            busy <= 1'b1;
        end else if (clr_any) begin
            busy <= 1'b0;
        end
    end

    // R3
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !busy);
    // R4
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> busy);
    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_p && !start_p) |=> !busy);
    // R7
    abort_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_p && busy && !done_p && !sw_clr && !(ext_mode && last_wr_p)) |=> busy);
    // R8
    ext_last_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && last_wr_p && !start_p) |=> !busy);
    // R8
    int_last_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && last_wr_p && busy && !done_p && !sw_clr) |=> busy);
endmodule

// File: rtl/dma_busy_wrdec.sv
// Module: decodes a CPU write into per-channel clear requests.
// Channel c is cleared by a 1 in bit WIDTH-1-c; reserved bits are dropped.
// Assumes wr_en is a single-cycle strobe.
module dma_busy_wrdec #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [NCH-1:0]   clr_req
);
    localparam int unsigned LSB = WIDTH - NCH;

    logic rsvd_hit;

    // Flag writes that touch only reserved bits (used by the check below).
    always_comb begin
        rsvd_hit = |wr_data[LSB-1:0];
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_dec
            // Reverse mapping: channel c sits at bit WIDTH-1-c.
            always_comb begin
                clr_req[c] = wr_en & wr_data[WIDTH-1-c];
            end
        end
    endgenerate

    // R2
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsvd_hit && wr_data[WIDTH-1:LSB] == '0) |-> clr_req == '0);
endmodule

// File: rtl/dma_busy_rdport.sv
// Module: registered CPU read port.
// Captures the flags, placed at their word positions, at the edge where rd_en
// is high; outputs zero after any edge without a read strobe.
module dma_busy_rdport #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [NCH-1:0]   busy,
    output logic [WIDTH-1:0] rd_data
);
    localparam int unsigned LSB = WIDTH - NCH;

    logic [WIDTH-1:0] word;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_map
            // Place channel c at bit WIDTH-1-c.
            always_comb begin
                word[WIDTH-1-c] = busy[c];
            end
        end
    endgenerate

    // Reserved field is tied low.
    always_comb begin
        word[LSB-1:0] = '0;
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= word;
        end else begin
            rd_data <= '0;
        end
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) rd_data[LSB-1:0] == '0);
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);
endmodule

// File: rtl/dma_busy_status.sv
// Module: top of the DMA channel busy-status register.
// One flag per channel, write-1-to-clear CPU access, one-cycle read latency.
// Assumes channel events are single-cycle pulses synchronous to clk.
module dma_busy_status #(
    parameter int unsigned NCH   = dma_busy_pkg::DEF_NCH,
    parameter int unsigned WIDTH = dma_busy_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ch_start,
    input  logic [NCH-1:0]   ch_last_wr,
    input  logic [NCH-1:0]   ch_done,
    input  logic [NCH-1:0]   ch_abort,
    input  logic [NCH-1:0]   ch_ext,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data
);
    logic [NCH-1:0] clr_req;
    logic [NCH-1:0] busy;

    dma_busy_wrdec #(.NCH(NCH), .WIDTH(WIDTH)) u_wrdec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_req (clr_req)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            dma_busy_flag u_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .start_p   (ch_start[c]),
                .done_p    (ch_done[c]),
                .last_wr_p (ch_last_wr[c]),
                .abort_p   (ch_abort[c]),
                .ext_mode  (ch_ext[c]),
                .sw_clr    (clr_req[c]),
                .busy      (busy[c])
            );
        end
    endgenerate

    dma_busy_rdport #(.NCH(NCH), .WIDTH(WIDTH)) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .busy    (busy),
        .rd_data (rd_data)
    );

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ch_start & clr_req) != '0) |=> (busy & $past(ch_start & clr_req)) == $past(ch_start & clr_req));
    // R10
    start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_start & ch_done) != '0) |=> (busy & $past(ch_start & ch_done)) == $past(ch_start & ch_done));
endmodule

// File: tb/dma_busy_status_tb.sv
`timescale 1ns/1ps
module dma_busy_status_tb;
    localparam int NCH = 8;
    localparam int W   = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] ch_start, ch_last_wr, ch_done, ch_abort, ch_ext;
    logic           wr_en, rd_en;
    logic [W-1:0]   wr_data;
    logic [W-1:0]   rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [NCH-1:0] model;
    logic [W-1:0]   exp_rd;

    dma_busy_status u_dut (
        .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .ch_last_wr(ch_last_wr),
        .ch_done(ch_done), .ch_abort(ch_abort), .ch_ext(ch_ext), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] to_word(input logic [NCH-1:0] f);
        logic [W-1:0] w = '0;
        for (int c = 0; c < NCH; c++) w[W-1-c] = f[c];
        return w;
    endfunction

    function automatic logic [NCH-1:0] next_flags(input logic [NCH-1:0] f);
        logic [NCH-1:0] n = f;
        for (int c = 0; c < NCH; c++) begin
            if (ch_start[c]) n[c] = 1'b1;
            else if (ch_done[c] || (ch_ext[c] && ch_last_wr[c]) || (wr_en && wr_data[W-1-c]))
                n[c] = 1'b0;
        end
        return n;
    endfunction

    task automatic idle_inputs();
        ch_start = '0; ch_last_wr = '0; ch_done = '0; ch_abort = '0;
        wr_en = 0; rd_en = 0; wr_data = '0;
    endtask

    // One cycle: inputs already set; predict, clock, compare.
    task automatic step(input string req);
        if (!rst_n) begin
            exp_rd = '0;
            model  = '0;
        end else begin
            exp_rd = rd_en ? to_word(model) : '0;
            model  = next_flags(model);
        end
        @(posedge clk);
        #1;
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp_rd);
        end
        idle_inputs();
    endtask

    task automatic do_read(input string req);
        rd_en = 1;
        step(req);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model = '0;
        ch_ext = '0;
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        // R3: reset clears flags and read data, even with a start pending
        ch_start = '1; rd_en = 1;
        step("R3");
        step("R3");
        rst_n = 1;
        do_read("R3");

        // R1/R4: each channel alone lands in bit 31-c
        for (int c = 0; c < NCH; c++) begin
            ch_start[c] = 1; step("R4");
            do_read("R1");
            wr_en = 1; wr_data = 32'h1 << (W-1-c); step("R6");
            do_read("R6");
        end

        // R11: read in the same cycle as a start returns the old value
        ch_start = 8'h0F; rd_en = 1; step("R11");
        do_read("R11");
        step("R11");

        // R6: write 0 leaves flags; R2: reserved-bit writes change nothing
        wr_en = 1; wr_data = 32'h0; step("R6");
        wr_en = 1; wr_data = 32'h00FF_FFFF; step("R2");
        do_read("R2");

        // R7: abort leaves flags set
        ch_abort = '1; step("R7");
        do_read("R7");

        // R5: completion clears
        ch_done = 8'h03; step("R5");
        do_read("R5");

        // R8: last-write start clears only in external mode
        ch_ext = 8'h04; ch_last_wr = 8'h0C; step("R8");
        do_read("R8");

        // R9: start beats write-1 clear
        ch_start = 8'h80; wr_en = 1; wr_data = 32'hFF00_0000; step("R9");
        do_read("R9");

        // R10: start plus completion ends set
        ch_start = 8'h40; ch_done = 8'h40; step("R10");
        do_read("R10");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            ch_ext     = ($urandom % 16 == 0) ? NCH'($urandom) : ch_ext;
            ch_start   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            ch_done    = NCH'($urandom) & NCH'($urandom);
            ch_last_wr = NCH'($urandom) & NCH'($urandom);
            ch_abort   = NCH'($urandom) & NCH'($urandom);
            wr_en      = ($urandom % 4 == 0);
            wr_data    = $urandom;
            rd_en      = ($urandom % 2 == 0);
            step("R11 random");
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule